// File: doc/BRIEF.md
# Audio Capture Buffer with Fill-Level and Overrun Interrupts

This block sits behind a digital audio receiver and stores the incoming samples in an on-chip buffer of 16-bit words while recording is switched on. A selectable sample width (16, 18, 20 or 24 bits) picks the top bits of the receiver's 24-bit left-aligned sample and right-justifies them. A 16-bit sample takes one buffer word. A wider sample takes two words: the upper bits come first, zero-extended, and the lower 16 bits follow. A host reads the buffer back one word at a time through a data register that pops a word on each read. It can also read the write and read pointers in word units.

Three sticky status flags report a fill level reached, a sample dropped for lack of room, and an external event. The host clears a flag by writing 1 to it. The single interrupt output is the OR of the flags whose enables are set. The fill-level enable is a 2-bit threshold selector: off, one eighth, one quarter or one half of the buffer depth. A clear bit in the control register empties the buffer and resets all of the logic state.

Top module: `capbuf_top`

## Requirements
- R1: A sample offered on `in_valid` is stored only while the record bit (bit 0 of the control register at offset 3) is 1. With the bit at 0 the write pointer does not move.
- R2: Format field bits 3:2 of the control register select the width: 00 = 16, 01 = 18, 10 = 20, 11 = 24 bits. The value kept is the top N bits of `in_data`, right-justified. For 16 bits one word is stored. For the wider widths two words are stored: value[31:16] first, then value[15:0].
- R3: A read at offset 0 returns the oldest buffered word one cycle later and advances the read pointer by one. A read from an empty buffer returns 0 and leaves the read pointer unchanged.
- R4: The write pointer (offset 1) and the read pointer (offset 2) count 16-bit words. Each stored word adds 1 to the write pointer, modulo the depth.
- R5: The buffer holds at most depth-1 words. A sample whose words do not all fit is dropped whole, the write pointer stays put, and status bit 1 (overrun) is set.
- R6: Level selector bits 1:0 of the enable register (offset 5) give the threshold: 00 = never, 01 = depth/8, 10 = depth/4, 11 = depth/2. Status bit 0 is set while the fill count (write pointer minus read pointer, modulo depth) is greater than or equal to the threshold.
- R7: A high `ext_evt` sets status bit 2.
- R8: The status register (offset 4) is sticky. Writing 1 to a bit clears it, unless the bit's condition still holds in that cycle.
- R9: `irq` is high when any status bit is set together with its enable: bit 0 with a selector other than 00, bit 1 with enable bit 2, bit 2 with enable bit 3.
- R10: Writing the control register with bit 1 set zeroes both pointers and all status bits, drops any half-written sample, and forces the record bit to 0.
- R11: After `rst`, the pointers, the status bits, `host_rdata` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe from the receiver, at least 3 cycles apart |
| in_data | input | 24 | Left-aligned sample |
| ext_evt | input | 1 | External event request |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register word offset |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid the cycle after `host_rd` |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that the write pointer only steps by one or returns to zero on a clear, and that no word is written when it would make the pointers meet. They also check that a read of an empty buffer leaves the read pointer alone, and that a clear leaves both pointers and the status at zero. Only the bench's scenarios can show the right-justified packing and word order for each width, and the threshold crossing for each selector code. The same holds for the set-wins-over-clear behaviour of a still-true level flag, the whole-sample drop at overrun, and the masking of each flag at `irq`.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [1:0] {FMT_16 = 2'd0, FMT_18 = 2'd1, FMT_20 = 2'd2, FMT_24 = 2'd3} fmt_e;
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_WPTR = 3'd1;
  localparam logic [2:0] OFF_RPTR = 3'd2;
  localparam logic [2:0] OFF_CTRL = 3'd3;
  localparam logic [2:0] OFF_STAT = 3'd4;
  localparam logic [2:0] OFF_IEN  = 3'd5;
  localparam int unsigned NFLAG   = 3;
  localparam int unsigned IN_W    = 24;
  localparam int unsigned WORD_W  = 16;
endpackage

// File: rtl/capbuf_mem.sv
module capbuf_mem #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/capbuf_pack.sv
module capbuf_pack
  import capbuf_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              record,
  input  fmt_e              fmt,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  input  logic [AW-1:0]     free,
  output logic              wr_v,
  output logic [WORD_W-1:0] wr_word,
  output logic              ovr_pulse
);
  logic [31:0]       justified;
  logic [1:0]        need;
  logic [AW+1:0]     room;
  logic [AW+1:0]     demand;
  logic              take;
  logic              fits;
  logic              pend;
  logic [WORD_W-1:0] lo_q;

  always_comb begin
    unique case (fmt)
      FMT_16: justified = {8'd0, in_data} >> 8;
      FMT_18: justified = {8'd0, in_data} >> 6;
      FMT_20: justified = {8'd0, in_data} >> 4;
      default: justified = {8'd0, in_data};
    endcase
    need   = (fmt == FMT_16) ? 2'd1 : 2'd2;
    room   = {2'b00, free};
    demand = (AW+2)'(need) + (AW+2)'(wr_v);
    fits   = room >= demand;
    take   = in_valid && record && !pend;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_v      <= 1'b0;
      pend      <= 1'b0;
      ovr_pulse <= 1'b0;
      wr_word   <= '0;
      lo_q      <= '0;
    end else begin
      wr_v      <= 1'b0;
      ovr_pulse <= 1'b0;
      if (pend) begin
        wr_v    <= 1'b1;
        wr_word <= lo_q;
        pend    <= 1'b0;
      end else if (take) begin
        if (fits) begin
          wr_v <= 1'b1;
          if (need == 2'd1) begin
            wr_word <= justified[15:0];
          end else begin
            wr_word <= justified[31:16];
            lo_q    <= justified[15:0];
            pend    <= 1'b1;
          end
        end else begin
          ovr_pulse <= 1'b1;
        end
      end
    end
  end

  AST_IN_SPACING: assert property (@(posedge clk) disable iff (rst)
    (in_valid && record) |-> !pend); // R2
endmodule

// File: rtl/capbuf_ptr.sv
module capbuf_ptr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_v,
  input  logic          pop_req,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] fill,
  output logic [AW-1:0] free,
  output logic          empty
);
  always_comb begin
    fill  = wptr - rptr;
    free  = ~fill;
    empty = (fill == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_v) wptr <= wptr + 1'b1;
      if (pop_req && !empty) rptr <= rptr + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_v |-> (AW'(wptr + 1'b1) != rptr)); // R5
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wptr != $past(wptr)) |-> ($past(clr) || wptr == AW'($past(wptr) + 1'b1))); // R4
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !clr) |=> (rptr == $past(rptr))); // R3
endmodule

// File: rtl/capbuf_irq.sv
module capbuf_irq
  import capbuf_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [1:0]       lvl_sel,
  input  logic             ovr_en,
  input  logic             ext_en,
  input  logic [AW-1:0]    fill,
  input  logic             ovr_pulse,
  input  logic             ext_evt,
  input  logic             w1c_we,
  input  logic [NFLAG-1:0] w1c_mask,
  output logic [NFLAG-1:0] stat,
  output logic             irq
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [AW:0]      thr;
  logic             lvl_hit;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] en_v;

  always_comb begin
    unique case (lvl_sel)
      2'd1: thr = (AW+1)'(DEPTH / 8);
      2'd2: thr = (AW+1)'(DEPTH / 4);
      2'd3: thr = (AW+1)'(DEPTH / 2);
      default: thr = '0;
    endcase
    lvl_hit = (lvl_sel != 2'd0) && ({1'b0, fill} >= thr);
    set_v   = {ext_evt, ovr_pulse, lvl_hit};
    clr_v   = w1c_we ? w1c_mask : '0;
    en_v    = {ext_en, ovr_en, (lvl_sel != 2'd0)};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= (stat & ~clr_v) | set_v;
      irq  <= |(stat & en_v);
    end
  end

  AST_LVL_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    ($rose(stat[0]) && !$past(clr)) |-> ($past(lvl_sel) != 2'd0)); // R6
endmodule

// File: rtl/capbuf_top.sv
module capbuf_top
  import capbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [23:0] in_data,
  input  logic        ext_evt,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [2:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        irq
);
  logic              record;
  fmt_e              fmt;
  logic [1:0]        lvl_sel;
  logic              ovr_en;
  logic              ext_en;
  logic              clr;
  logic              pop_req;
  logic              wr_v;
  logic [WORD_W-1:0] wr_word;
  logic              ovr_pulse;
  logic [ADDR_W-1:0] wptr, rptr, fill, free;
  logic              empty;
  logic [NFLAG-1:0]  stat;
  logic [WORD_W-1:0] mem_q;
  logic [WORD_W-1:0] reg_q;
  logic              sel_data;
  logic              empty_hit;

  assign clr     = host_wr && (host_addr == OFF_CTRL) && host_wdata[1];
  assign pop_req = host_rd && (host_addr == OFF_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      record  <= 1'b0;
      fmt     <= FMT_16;
      lvl_sel <= 2'd0;
      ovr_en  <= 1'b0;
      ext_en  <= 1'b0;
    end else if (host_wr) begin
      if (host_addr == OFF_CTRL) begin
        record <= host_wdata[0] && !host_wdata[1];
        fmt    <= fmt_e'(host_wdata[3:2]);
      end
      if (host_addr == OFF_IEN) begin
        lvl_sel <= host_wdata[1:0];
        ovr_en  <= host_wdata[2];
        ext_en  <= host_wdata[3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_data  <= 1'b0;
      empty_hit <= 1'b0;
    end else if (host_rd) begin
      sel_data  <= (host_addr == OFF_DATA);
      empty_hit <= empty;
      unique case (host_addr)
        OFF_WPTR: reg_q <= WORD_W'(wptr);
        OFF_RPTR: reg_q <= WORD_W'(rptr);
        OFF_CTRL: reg_q <= {12'd0, fmt, 1'b0, record};
        OFF_STAT: reg_q <= WORD_W'(stat);
        OFF_IEN:  reg_q <= {12'd0, ext_en, ovr_en, lvl_sel};
        default:  reg_q <= '0;
      endcase
    end
  end

  assign host_rdata = sel_data ? (empty_hit ? '0 : mem_q) : reg_q;

  capbuf_pack #(.AW(ADDR_W)) u_pack (
    .clk(clk), .rst(rst), .clr(clr), .record(record), .fmt(fmt),
    .in_valid(in_valid), .in_data(in_data), .free(free),
    .wr_v(wr_v), .wr_word(wr_word), .ovr_pulse(ovr_pulse)
  );

  capbuf_ptr #(.AW(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .clr(clr), .wr_v(wr_v), .pop_req(pop_req),
    .wptr(wptr), .rptr(rptr), .fill(fill), .free(free), .empty(empty)
  );

  capbuf_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
    .clk(clk), .we(wr_v && !clr), .waddr(wptr), .wdata(wr_word),
    .re(pop_req), .raddr(rptr), .rdata(mem_q)
  );

  capbuf_irq #(.AW(ADDR_W)) u_irq (
    .clk(clk), .rst(rst), .clr(clr), .lvl_sel(lvl_sel), .ovr_en(ovr_en),
    .ext_en(ext_en), .fill(fill), .ovr_pulse(ovr_pulse), .ext_evt(ext_evt),
    .w1c_we(host_wr && host_addr == OFF_STAT), .w1c_mask(host_wdata[NFLAG-1:0]),
    .stat(stat), .irq(irq)
  );

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (wptr == '0 && rptr == '0 && stat == '0 && !record)); // R10
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (!record && !wr_v && !$past(record)) |=> !wr_v); // R1
endmodule

// File: tb/sim_capbuf_top.sv
module sim_capbuf_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int NV = 8;
  // {fmt[1:0], in_data[23:0], hi[15:0], lo[15:0]}
  localparam logic [57:0] VEC [NV] = '{
    {2'd0, 24'hABCDEF, 16'h0000, 16'hABCD},
    {2'd1, 24'hABCDEF, 16'h0002, 16'hAF37},
    {2'd2, 24'hABCDEF, 16'h000A, 16'hBCDE},
    {2'd3, 24'hABCDEF, 16'h00AB, 16'hCDEF},
    {2'd0, 24'h123456, 16'h0000, 16'h1234},
    {2'd1, 24'h123456, 16'h0000, 16'h48D1},
    {2'd2, 24'h123456, 16'h0001, 16'h2345},
    {2'd3, 24'h123456, 16'h0012, 16'h3456}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, ext_evt = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [23:0] in_data = '0;
  logic [2:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic irq;
  int checks = 0, failures = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  capbuf_top #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .ext_evt(ext_evt),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic push(input logic [23:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0;
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0;
    // R11 reset state
    check("R11 rdata", host_rdata, 16'h0);
    check("R11 irq", {15'd0, irq}, 16'h0);
    bus_read(3'd1, rv); check("R11 wptr", rv, 16'h0);
    bus_read(3'd4, rv); check("R11 stat", rv, 16'h0);

    // R1 record off: sample ignored
    push(24'h111111);
    bus_read(3'd1, rv); check("R1 wptr idle", rv, 16'h0);
    // R3 empty read
    bus_read(3'd0, rv); check("R3 empty data", rv, 16'h0);
    bus_read(3'd2, rv); check("R3 empty rptr", rv, 16'h0);

    // R2 format table
    for (int v = 0; v < NV; v++) begin
      bus_write(3'd3, {12'd0, VEC[v][57:56], 2'b01});
      push(VEC[v][55:32]);
      if (VEC[v][57:56] != 2'd0) begin
        bus_read(3'd0, rv); check("R2 hi word", rv, VEC[v][31:16]);
      end
      bus_read(3'd0, rv); check("R2 lo word", rv, VEC[v][15:0]);
    end

    // R10 clear
    bus_write(3'd3, 16'h0002);
    bus_read(3'd1, rv); check("R10 wptr", rv, 16'h0);
    bus_read(3'd2, rv); check("R10 rptr", rv, 16'h0);
    bus_read(3'd3, rv); check("R10 record off", rv, 16'h0);

    // R4 pointers in words
    bus_write(3'd3, 16'h0001);
    push(24'h010000); push(24'h020000); push(24'h030000);
    bus_read(3'd1, rv); check("R4 wptr three", rv, 16'd3);
    bus_read(3'd0, rv); check("R3 oldest word", rv, 16'h0100);
    bus_read(3'd2, rv); check("R4 rptr one", rv, 16'd1);
    bus_write(3'd3, 16'h000D);
    push(24'h000000);
    bus_read(3'd1, rv); check("R4 wide adds two", rv, 16'd5);

    // R6 level, depth 32: selector 01 -> 4 words
    bus_write(3'd3, 16'h0002); bus_write(3'd3, 16'h0001);
    bus_write(3'd5, 16'h0001);
    push(24'h0); push(24'h0); push(24'h0); idle(3);
    bus_read(3'd4, rv); check("R6 below eighth", rv & 16'h1, 16'h0);
    push(24'h0); idle(3);
    bus_read(3'd4, rv); check("R6 at eighth", rv & 16'h1, 16'h1);
    check("R9 level irq", {15'd0, irq}, 16'h1);
    bus_write(3'd4, 16'h0001); idle(2);
    bus_read(3'd4, rv); check("R8 set wins", rv & 16'h1, 16'h1);
    bus_read(3'd0, rv);
    bus_write(3'd4, 16'h0001); idle(3);
    bus_read(3'd4, rv); check("R8 cleared", rv & 16'h1, 16'h0);
    check("R9 irq dropped", {15'd0, irq}, 16'h0);
    bus_write(3'd5, 16'h0002);
    push(24'h0); push(24'h0); push(24'h0); push(24'h0); idle(3);
    bus_read(3'd4, rv); check("R6 below quarter", rv & 16'h1, 16'h0);
    push(24'h0); idle(3);
    bus_read(3'd4, rv); check("R6 at quarter", rv & 16'h1, 16'h1);
    bus_write(3'd5, 16'h0000);
    bus_write(3'd4, 16'h0001); idle(3);
    bus_read(3'd4, rv); check("R6 selector off", rv & 16'h1, 16'h0);
    check("R9 no irq off", {15'd0, irq}, 16'h0);

    // R5 overrun
    bus_write(3'd3, 16'h0002); bus_write(3'd3, 16'h0001);
    bus_write(3'd5, 16'h0004);
    for (int k = 0; k < 31; k++) push({8'(k + 1), 16'h0});
    bus_read(3'd1, rv); check("R5 full wptr", rv, 16'd31);
    bus_read(3'd4, rv); check("R5 no overrun yet", rv & 16'h2, 16'h0);
    push(24'hFF0000); idle(3);
    bus_read(3'd1, rv); check("R5 dropped wptr", rv, 16'd31);
    bus_read(3'd4, rv); check("R5 overrun flag", rv & 16'h2, 16'h2);
    check("R9 overrun irq", {15'd0, irq}, 16'h1);
    bus_read(3'd0, rv); check("R5 data intact", rv, 16'h0100);
    bus_write(3'd3, 16'h000D);
    push(24'h777777);
    bus_read(3'd1, rv); check("R5 wide dropped whole", rv, 16'd31);

    // R7 external event
    bus_write(3'd3, 16'h0002);
    bus_write(3'd5, 16'h0000);
    @(negedge clk); ext_evt = 1'b1; @(negedge clk); ext_evt = 1'b0; idle(2);
    bus_read(3'd4, rv); check("R7 ext flag", rv, 16'h4);
    check("R9 ext masked", {15'd0, irq}, 16'h0);
    bus_write(3'd5, 16'h0008); idle(2);
    check("R9 ext irq", {15'd0, irq}, 16'h1);
    bus_write(3'd4, 16'h0004); idle(2);
    bus_read(3'd4, rv); check("R8 ext cleared", rv, 16'h0);
    check("R9 irq low", {15'd0, irq}, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule